// File: doc/BRIEF.md
# Serial Divider-Word Load Port

This block is the programming port of a frequency synthesizer. A host sends words one bit at a time on a serial data pin and marks each bit with a rising edge on a shift clock pin. Each word has 14 bits of divide ratio followed by one routing bit. When a load-enable pin is raised, the 14-bit ratio is copied into one of two holding registers. One holds the reference divider's terminal count and the other holds the feedback divider's. The routing bit chooses which of the two is written. The two register outputs drive the dividers directly.

All three port pins are asynchronous to the system clock. They pass through a two-stage synchronizer. A shift-clock rising edge is found by comparing the synchronized level with its value one cycle earlier.

A two-state machine follows the synchronized load enable:

- `S_IDLE`: load enable is low and both holding registers keep their values. The transition `S_IDLE -> S_LOAD` is taken when load enable is seen high.
- `S_LOAD`: on every cycle, the word in the shift path is written into the register picked by its routing bit. The transition `S_LOAD -> S_IDLE` is taken when load enable is seen low.

Because `S_LOAD` writes on every cycle, the holding registers behave as transparent latches for as long as load enable stays high.

Top module: `synth_load_port`

## Requirements
- R1: After reset, the reference output is REF_INIT (default 100) and the feedback output is FB_INIT (default 1000). Neither default is zero.
- R2: Each low-to-high transition of the shift clock shifts exactly one bit into the shift path. A high-to-low transition shifts nothing.
- R3: The shift path keeps only the last 15 bits shifted in. Of those, the first 14 form the ratio, sent most significant bit first. The fifteenth (last) bit is the routing bit.
- R4: A load with routing bit 1 writes the 14-bit ratio into the reference output.
- R5: A load with routing bit 0 writes the 14-bit ratio into the feedback output.
- R6: During a load, the register that was not selected keeps its value.
- R7: While load enable is low, shifting any number of bits changes neither output.
- R8: While load enable is held high, each new word shifted in is routed and written without a further enable edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Serial shift clock (asynchronous) |
| sdata_in | input | 1 | Serial data bit (asynchronous) |
| load_en_in | input | 1 | Load enable, normally low and pulsed high (asynchronous) |
| ref_div_o | output | 14 | Reference divider terminal count |
| fb_div_o | output | 14 | Feedback divider terminal count |

## Verification
The bench uses several kinds of traffic:

- **Words with each routing value.** A word with routing bit 1 and a word with routing bit 0 are loaded in turn. This shows whether routing reaches the correct register and leaves the other one untouched.
- **Shifting with load enable low.** Whole words are shifted with no load pulse. Any leakage from the shift path into the outputs shows up here.
- **An overlong burst.** Twenty bits are sent before a load, so leading junk must fall out. This separates a correct 15-bit window from an off-by-one bit alignment.
- **Shifting with load enable held high.** Words are shifted while load enable stays high. This exercises the transparent behaviour of `S_LOAD`.

The routing bit changes as the bits move through the shift path. The bench model therefore routes every intermediate word in the same way the hardware does.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int DATA_W = 14;
    localparam int SR_W   = DATA_W + 1;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_LOAD = 1'b1
    } ld_state_t;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sp_shift.sv
module sp_shift #(
    parameter int SR_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_s,
    input  logic            sdat_s,
    output logic [SR_W-1:0] word_o
);
    logic sclk_d;
    logic step;

    assign step = sclk_s & ~sclk_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            word_o <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (step) word_o <= {word_o[SR_W-2:0], sdat_s};
        end
    end

    // R2: no shift without a rising shift clock
    a_r2_no_edge_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sclk_s) |=> $stable(word_o));
    // R2: a rising shift clock takes in exactly the current data bit
    a_r2_one_bit_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_s) |=> word_o == {$past(word_o[SR_W-2:0]), $past(sdat_s)});
endmodule

// File: rtl/sp_latch_ctrl.sv
module sp_latch_ctrl
    import sp_pkg::*;
#(
    parameter int              DATA_W   = 14,
    parameter logic [DATA_W-1:0] REF_INIT = 14'd100,
    parameter logic [DATA_W-1:0] FB_INIT  = 14'd1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le_s,
    input  logic [DATA_W:0]   word_i,
    output logic [DATA_W-1:0] ref_q,
    output logic [DATA_W-1:0] fb_q
);
    ld_state_t state, state_nx;
    logic      wr_ref, wr_fb;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (le_s)  state_nx = S_LOAD;
            S_LOAD: if (!le_s) state_nx = S_IDLE;
        endcase
    end

    // outputs of the machine: write strobes
    always_comb begin
        wr_ref = 1'b0;
        wr_fb  = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_LOAD: begin
                wr_ref = word_i[0];
                wr_fb  = ~word_i[0];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= REF_INIT;
            fb_q  <= FB_INIT;
        end else begin
            if (wr_ref) ref_q <= word_i[DATA_W:1];
            if (wr_fb)  fb_q  <= word_i[DATA_W:1];
        end
    end

    // R7: idle keeps both registers
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_IDLE |=> $stable(ref_q) && $stable(fb_q));
    // R4: routing bit 1 loads the reference register
    a_r4_ref_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD && word_i[0]) |=> ref_q == $past(word_i[DATA_W:1]));
    // R5: routing bit 0 loads the feedback register
    a_r5_fb_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD && !word_i[0]) |=> fb_q == $past(word_i[DATA_W:1]));
    // R6: the unselected register is untouched
    a_r6_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_LOAD |=> (word_i[0] ? $stable(fb_q) : $stable(ref_q)) || $past(state) != S_LOAD);
endmodule

// File: rtl/synth_load_port.sv
module synth_load_port
    import sp_pkg::*;
#(
    parameter logic [DATA_W-1:0] REF_INIT = 14'd100,
    parameter logic [DATA_W-1:0] FB_INIT  = 14'd1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic              load_en_in,
    output logic [DATA_W-1:0] ref_div_o,
    output logic [DATA_W-1:0] fb_div_o
);
    logic [2:0]      pins_s;
    logic [SR_W-1:0] word;

    sp_sync #(.W(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({load_en_in, sdata_in, sclk_in}),
        .sync_o  (pins_s)
    );

    sp_shift #(.SR_W(SR_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (pins_s[0]),
        .sdat_s (pins_s[1]),
        .word_o (word)
    );

    sp_latch_ctrl #(
        .DATA_W   (DATA_W),
        .REF_INIT (REF_INIT),
        .FB_INIT  (FB_INIT)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .le_s   (pins_s[2]),
        .word_i (word),
        .ref_q  (ref_div_o),
        .fb_q   (fb_div_o)
    );
endmodule

// File: tb/synth_load_port_tb_top.sv
module synth_load_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b0, sdata_in = 1'b0, load_en_in = 1'b0;
    logic [13:0] ref_div_o, fb_div_o;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference model
    logic [14:0] m_sr  = '0;
    logic [13:0] m_ref = 14'd100;
    logic [13:0] m_fb  = 14'd1000;
    bit          m_le  = 1'b0;
    bit          cmp_en = 1'b0;
    string       phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_load_port dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .load_en_in(load_en_in), .ref_div_o(ref_div_o), .fb_div_o(fb_div_o)
    );

    task automatic check(string req, logic [13:0] act, logic [13:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic m_route();
        if (m_sr[0]) m_ref = m_sr[14:1];
        else         m_fb  = m_sr[14:1];
    endtask

    // compare against the model on every clock while it is settled
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            check(phase, ref_div_o, m_ref, "ref");
            check(phase, fb_div_o,  m_fb,  "fb");
        end
    end

    task automatic shift_bit(bit b);
        sdata_in = b;
        repeat (3) @(posedge clk);
        sclk_in = 1'b1;
        repeat (3) @(posedge clk);
        sclk_in = 1'b0;
        repeat (3) @(posedge clk);
        m_sr = {m_sr[13:0], b};
        if (m_le) m_route();
    endtask

    task automatic send_word(logic [13:0] ratio, bit route);
        for (int i = 13; i >= 0; i--) shift_bit(ratio[i]);
        shift_bit(route);
    endtask

    task automatic le_raise();
        cmp_en = 1'b0;
        load_en_in = 1'b1;
        m_le = 1'b1;
        m_route();
        repeat (6) @(posedge clk);
    endtask

    task automatic le_drop();
        load_en_in = 1'b0;
        m_le = 1'b0;
        repeat (8) @(posedge clk);
        cmp_en = 1'b1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", ref_div_o, 14'd100,  "ref reset");
        check("R1", fb_div_o,  14'd1000, "fb reset");
        cmp_en = 1'b1;

        // R7: shifting with load enable low leaves outputs alone
        phase = "R7";
        send_word(14'h1234, 1'b1);
        send_word(14'h0FFF, 1'b0);
        @(negedge clk);
        check("R7", ref_div_o, 14'd100,  "ref after idle shifting");
        check("R7", fb_div_o,  14'd1000, "fb after idle shifting");

        // R4/R6: route to reference
        phase = "R4";
        send_word(14'h1234, 1'b1);
        le_raise(); le_drop();
        @(negedge clk);
        check("R4", ref_div_o, 14'h1234, "ref loaded");
        check("R6", fb_div_o,  14'd1000, "fb kept");

        // R5/R6: route to feedback
        phase = "R5";
        send_word(14'h0ABC, 1'b0);
        le_raise(); le_drop();
        @(negedge clk);
        check("R5", fb_div_o,  14'h0ABC, "fb loaded");
        check("R6", ref_div_o, 14'h1234, "ref kept");

        // R3/R2: overlong burst, only last 15 bits count
        phase = "R3";
        for (int i = 0; i < 5; i++) shift_bit(1'b1);
        send_word(14'h2001, 1'b1);
        le_raise(); le_drop();
        @(negedge clk);
        check("R3", ref_div_o, 14'h2001, "ref after 20-bit burst");
        check("R2", fb_div_o,  14'h0ABC, "fb after 20-bit burst");

        // R8: keep load enable high while shifting
        phase = "R8";
        le_raise();
        send_word(14'h3C5A, 1'b0);
        send_word(14'h0777, 1'b1);
        le_drop();
        @(negedge clk);
        check("R8", fb_div_o,  m_fb,     "fb while enable high");
        check("R8", ref_div_o, 14'h0777, "ref while enable high");

        // R4: all-ones ratio
        phase = "R4";
        send_word(14'h3FFF, 1'b1);
        le_raise(); le_drop();
        @(negedge clk);
        check("R4", ref_div_o, 14'h3FFF, "ref all ones");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule